// File: doc/BRIEF.md
# Low-Power Mode Controller

This block sits beside a small processor and decides which parts of the system keep their clocks. Software writes two things through a register port: a frequency level from 0 to 15, which is passed straight to an external clock synthesizer, and a request for one of three low-power modes. The controller then drives one clock-enable line for each of three domains: the CPU, the tick timer and the interrupt controller. It also drives a request to lower the supply voltage.

Each low-power mode keeps a different set of domains running and can be left by a different set of events. In doze, only the timer and the interrupt controller keep their clocks, and either a timer tick or a pending interrupt ends it. In sleep, only the interrupt controller keeps its clock, the voltage is lowered, and only an interrupt ends it. In suspend, every clock stops, the voltage is lowered, and only reset ends it. On a wake-up the voltage request drops at once. The clocks stay gated for a software-set settle time, so that the supply can recover before the CPU runs again.

A status register reports the current mode, whether a wake-up is in progress, and what caused the most recent wake-up. The timer and interrupt inputs pass through a parameterised synchronizer before the mode logic uses them.

Top module: `lpm_ctrl`

## Requirements
- R1: The frequency level is CTRL bits [3:0] (register address 0). It appears on `freq_lvl` and reads back at address 0 from the cycle after the write, in every mode. After reset it is 0.
- R2: After reset the controller is in normal mode. All three clock enables are 1, `volt_low_req` is 0, the settle register holds SETTLE_RST, and the status wake cause is 3 (reset).
- R3: A write to CTRL with bit 4 (doze), bit 5 (sleep) or bit 6 (suspend) set enters a low-power mode. When several of these bits are set, the deepest mode wins (suspend over sleep over doze). Mode bits are ignored unless the controller is in normal mode with no wake-up in progress.
- R4: The clock enables and voltage request follow the mode. Normal: all enables 1, voltage request 0. Doze: CPU 0, timer 1, interrupt controller 1, voltage request 0. Sleep: only the interrupt controller 1, voltage request 1. Suspend: all enables 0, voltage request 1.
- R5: In doze, a timer event or a pending interrupt starts a wake-up.
- R6: In sleep, timer events are ignored. Only a pending interrupt starts a wake-up.
- R7: In suspend, timer events and interrupts are both ignored. Only reset returns the controller to normal mode.
- R8: A wake-up drops `volt_low_req` on the edge where it starts. The gated enables keep their low-power values for N+1 more cycles, where N is the settle register (address 1, bits [SETTLE_W-1:0]). Normal mode and all enables return on the edge N+1 cycles after the wake-up edge.
- R9: The status register is at address 2 and is read-only. Bits [1:0] hold the mode (0 normal, 1 doze, 2 sleep, 3 suspend). Bit 2 is 1 during a wake-up. Bits [4:3] hold the last wake cause (0 none, 1 timer, 2 interrupt, 3 reset). If a timer event and an interrupt start a wake-up on the same edge, the cause is 2.
- R10: `tick_evt` and `irq_pend` pass through SYNC_STAGES flops. An event present before edge k starts a wake-up on edge k+SYNC_STAGES, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational on address) |
| tick_evt | input | 1 | Tick-timer event |
| irq_pend | input | 1 | Interrupt pending |
| freq_lvl | output | FREQ_W | Frequency level to the clock synthesizer |
| cpu_clk_en | output | 1 | CPU domain clock enable |
| tick_clk_en | output | 1 | Tick-timer domain clock enable |
| pic_clk_en | output | 1 | Interrupt-controller domain clock enable |
| volt_low_req | output | 1 | Voltage-reduction request |

## Verification
The bench builds the block with FREQ_W=4, DATA_W=8, SYNC_STAGES=2, SETTLE_W=4 and SETTLE_RST=2. The 4-bit settle field allows both settle extremes, 0 and 15, to be tested in a few cycles, so the timing of clock re-enable can be checked at each end of its range. Two synchronizer stages put a visible gap between an event and its effect. This makes the "not before edge k+2" half of R10 observable, along with the behaviour of mode writes that arrive during a wake-up.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

   typedef enum logic [1:0] {
      MODE_RUN   = 2'd0,
      MODE_DOZE  = 2'd1,
      MODE_SLEEP = 2'd2,
      MODE_SUSP  = 2'd3
   } lpm_mode_e;

   typedef enum logic [1:0] {
      WAKE_NONE  = 2'd0,
      WAKE_TICK  = 2'd1,
      WAKE_IRQ   = 2'd2,
      WAKE_RESET = 2'd3
   } lpm_cause_e;

   localparam int REG_CTRL    = 0;
   localparam int REG_SETTLE  = 1;
   localparam int REG_STATUS  = 2;

   localparam int NUM_DOMAINS = 3;
   localparam int DOM_CPU     = 0;
   localparam int DOM_TICK    = 1;
   localparam int DOM_PIC     = 2;

   localparam int STATUS_W    = 5;

endpackage

// File: rtl/lpm_sync.sv
module lpm_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("lpm_sync: WIDTH must be at least 1");
      end
      if (STAGES < 0) begin : g_bad_stages
         $error("lpm_sync: STAGES must not be negative");
      end

      if (STAGES == 0) begin : g_pass
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign q = d;
      end else begin : g_chain
         logic [WIDTH-1:0] stage_q [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
            end else begin
               stage_q[0] <= d;
               for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
            end
         end
         assign q = stage_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/lpm_regs.sv
module lpm_regs
   import lpm_pkg::*;
#(
   parameter int FREQ_W     = 4,
   parameter int SETTLE_W   = 8,
   parameter int DATA_W     = 8,
   parameter int ADDR_W     = 2,
   parameter int SETTLE_RST = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [DATA_W-1:0]   wdata,
   output logic [DATA_W-1:0]   rdata,
   input  lpm_mode_e           mode_i,
   input  logic                waking_i,
   input  lpm_cause_e          cause_i,
   output logic [FREQ_W-1:0]   freq_o,
   output logic [SETTLE_W-1:0] settle_o,
   output logic                mode_req_o,
   output lpm_mode_e           mode_sel_o
);

   localparam int BIT_DOZE  = FREQ_W;
   localparam int BIT_SLEEP = FREQ_W + 1;
   localparam int BIT_SUSP  = FREQ_W + 2;

   localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(REG_CTRL);
   localparam logic [ADDR_W-1:0] A_SETTLE = ADDR_W'(REG_SETTLE);
   localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(REG_STATUS);

   generate
      if (DATA_W < FREQ_W + 3) begin : g_bad_ctrl
         $error("lpm_regs: DATA_W too narrow for CTRL");
      end
      if (SETTLE_RST < 0 || SETTLE_RST >= (1 << SETTLE_W)) begin : g_bad_rst
         $error("lpm_regs: SETTLE_RST out of range");
      end
   endgenerate

   logic wr_ctrl;
   logic wr_settle;
   logic unused_wdata;

   assign wr_ctrl      = wr_en && (addr == A_CTRL);
   assign wr_settle    = wr_en && (addr == A_SETTLE);
   assign unused_wdata = ^wdata;

   // deepest requested mode wins
   always_comb begin
      if (wdata[BIT_SUSP])       mode_sel_o = MODE_SUSP;
      else if (wdata[BIT_SLEEP]) mode_sel_o = MODE_SLEEP;
      else if (wdata[BIT_DOZE])  mode_sel_o = MODE_DOZE;
      else                       mode_sel_o = MODE_RUN;
   end

   assign mode_req_o = wr_ctrl && (mode_sel_o != MODE_RUN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         freq_o   <= '0;
         settle_o <= SETTLE_W'(SETTLE_RST);
      end else begin
         if (wr_ctrl)   freq_o   <= wdata[FREQ_W-1:0];
         if (wr_settle) settle_o <= wdata[SETTLE_W-1:0];
      end
   end

   always_comb begin
      case (addr)
         A_CTRL:   rdata = DATA_W'(freq_o);
         A_SETTLE: rdata = DATA_W'(settle_o);
         A_STATUS: rdata = DATA_W'({cause_i, waking_i, mode_i});
         default:  rdata = '0;
      endcase
   end

   assert_freq_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl |=> (freq_o == $past(wdata[FREQ_W-1:0])));

endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
   import lpm_pkg::*;
#(
   parameter int SETTLE_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                mode_req,
   input  lpm_mode_e           mode_sel,
   input  logic                tick_s,
   input  logic                irq_s,
   input  logic [SETTLE_W-1:0] settle_val,
   output lpm_mode_e           mode_o,
   output logic                waking_o,
   output lpm_cause_e          cause_o,
   output logic                volt_low_o
);

   generate
      if (SETTLE_W < 1) begin : g_bad_settle
         $error("lpm_fsm: SETTLE_W must be at least 1");
      end
   endgenerate

   logic [SETTLE_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_o   <= MODE_RUN;
         waking_o <= 1'b0;
         cnt_q    <= '0;
         cause_o  <= WAKE_RESET;
      end else if (waking_o) begin
         if (cnt_q == '0) begin
            mode_o   <= MODE_RUN;
            waking_o <= 1'b0;
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end else begin
         case (mode_o)
            MODE_RUN: begin
               if (mode_req) mode_o <= mode_sel;
            end
            MODE_DOZE: begin
               if (irq_s) begin
                  waking_o <= 1'b1;
                  cnt_q    <= settle_val;
                  cause_o  <= WAKE_IRQ;
               end else if (tick_s) begin
                  waking_o <= 1'b1;
                  cnt_q    <= settle_val;
                  cause_o  <= WAKE_TICK;
               end
            end
            MODE_SLEEP: begin
               if (irq_s) begin
                  waking_o <= 1'b1;
                  cnt_q    <= settle_val;
                  cause_o  <= WAKE_IRQ;
               end
            end
            default: ; // suspend: only reset leaves
         endcase
      end
   end

   assign volt_low_o = !waking_o && (mode_o == MODE_SLEEP || mode_o == MODE_SUSP);

   assert_settle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (waking_o && cnt_q != '0) |=> (waking_o && mode_o == $past(mode_o)));

   assert_susp_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == MODE_SUSP && !waking_o) |=> (mode_o == MODE_SUSP));

   assert_sleep_tick_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == MODE_SLEEP && !waking_o && !irq_s) |=> (mode_o == MODE_SLEEP && !waking_o));

   assert_entry_by_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == MODE_RUN && !waking_o && !mode_req) |=> (mode_o == MODE_RUN));

   assert_doze_wake_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == MODE_DOZE && !waking_o && (tick_s || irq_s)) |=> waking_o);

endmodule

// File: rtl/lpm_gate.sv
module lpm_gate
   import lpm_pkg::*;
#(
   parameter int NUM_DOM = NUM_DOMAINS
) (
   input  lpm_mode_e          mode_i,
   output logic [NUM_DOM-1:0] en_o
);

   generate
      if (NUM_DOM < 1 || NUM_DOM > 3) begin : g_bad_dom
         $error("lpm_gate: NUM_DOM must be 1 to 3");
      end
      // domain d keeps its clock while the mode depth does not exceed d
      for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
         assign en_o[d] = (int'(mode_i) <= d);
      end
   endgenerate

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
   import lpm_pkg::*;
#(
   parameter int FREQ_W      = 4,
   parameter int SETTLE_W    = 8,
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 2,
   parameter int SYNC_STAGES = 2,
   parameter int SETTLE_RST  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              tick_evt,
   input  logic              irq_pend,
   output logic [FREQ_W-1:0] freq_lvl,
   output logic              cpu_clk_en,
   output logic              tick_clk_en,
   output logic              pic_clk_en,
   output logic              volt_low_req
);

   generate
      if (FREQ_W < 1) begin : g_bad_freq
         $error("lpm_ctrl: FREQ_W must be at least 1");
      end
      if (DATA_W < SETTLE_W || DATA_W < STATUS_W) begin : g_bad_data
         $error("lpm_ctrl: DATA_W too narrow");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("lpm_ctrl: ADDR_W must be at least 2");
      end
   endgenerate

   logic                   tick_s;
   logic                   irq_s;
   logic                   mode_req;
   lpm_mode_e              mode_sel;
   lpm_mode_e              mode_q;
   logic                   waking;
   lpm_cause_e             cause;
   logic [SETTLE_W-1:0]    settle_val;
   logic [NUM_DOMAINS-1:0] dom_en;

   lpm_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({irq_pend, tick_evt}),
      .q     ({irq_s, tick_s})
   );

   lpm_regs #(
      .FREQ_W     (FREQ_W),
      .SETTLE_W   (SETTLE_W),
      .DATA_W     (DATA_W),
      .ADDR_W     (ADDR_W),
      .SETTLE_RST (SETTLE_RST)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (reg_wr),
      .addr       (reg_addr),
      .wdata      (reg_wdata),
      .rdata      (reg_rdata),
      .mode_i     (mode_q),
      .waking_i   (waking),
      .cause_i    (cause),
      .freq_o     (freq_lvl),
      .settle_o   (settle_val),
      .mode_req_o (mode_req),
      .mode_sel_o (mode_sel)
   );

   lpm_fsm #(.SETTLE_W(SETTLE_W)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_req   (mode_req),
      .mode_sel   (mode_sel),
      .tick_s     (tick_s),
      .irq_s      (irq_s),
      .settle_val (settle_val),
      .mode_o     (mode_q),
      .waking_o   (waking),
      .cause_o    (cause),
      .volt_low_o (volt_low_req)
   );

   lpm_gate #(.NUM_DOM(NUM_DOMAINS)) u_gate (
      .mode_i (mode_q),
      .en_o   (dom_en)
   );

   assign cpu_clk_en  = dom_en[DOM_CPU];
   assign tick_clk_en = dom_en[DOM_TICK];
   assign pic_clk_en  = dom_en[DOM_PIC];

   assert_run_all_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_RUN) |-> (cpu_clk_en && tick_clk_en && pic_clk_en && !volt_low_req));

   assert_volt_gates_R4: assert property (@(posedge clk) disable iff (!rst_n)
      volt_low_req |-> (!cpu_clk_en && !tick_clk_en));

   assert_wake_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(waking) |-> (!cpu_clk_en && !volt_low_req));

   assert_pic_off_susp_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !pic_clk_en |-> volt_low_req);

endmodule

// File: tb/lpm_ctrl_tb_top.sv
module lpm_ctrl_tb_top;

   localparam int FREQ_W = 4;
   localparam int SETTLE_W = 4;
   localparam int DATA_W = 8;
   localparam int ADDR_W = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              reg_wr = 1'b0;
   logic [ADDR_W-1:0] reg_addr = '0;
   logic [DATA_W-1:0] reg_wdata = '0;
   logic [DATA_W-1:0] reg_rdata;
   logic              tick_evt = 1'b0;
   logic              irq_pend = 1'b0;
   logic [FREQ_W-1:0] freq_lvl;
   logic              cpu_clk_en, tick_clk_en, pic_clk_en, volt_low_req;

   int  checks = 0;
   int  errors = 0;
   bit  done = 1'b0;

   lpm_ctrl #(
      .FREQ_W(FREQ_W), .SETTLE_W(SETTLE_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
      .SYNC_STAGES(2), .SETTLE_RST(2)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_evt(tick_evt),
      .irq_pend(irq_pend), .freq_lvl(freq_lvl), .cpu_clk_en(cpu_clk_en),
      .tick_clk_en(tick_clk_en), .pic_clk_en(pic_clk_en), .volt_low_req(volt_low_req)
   );

   always #10 clk = ~clk;

   // {freq[3:0], mode bits {susp,sleep,doze}, exp mode[1:0], cpu, tick, pic, volt}
   localparam logic [12:0] VEC [8] = '{
      {4'd5,  3'b000, 2'd0, 4'b1110},
      {4'd15, 3'b001, 2'd1, 4'b0110},
      {4'd0,  3'b010, 2'd2, 4'b0011},
      {4'd9,  3'b100, 2'd3, 4'b0001},
      {4'd3,  3'b011, 2'd2, 4'b0011},
      {4'd12, 3'b111, 2'd3, 4'b0001},
      {4'd6,  3'b101, 2'd3, 4'b0001},
      {4'd10, 3'b110, 2'd3, 4'b0001}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // all tasks start and end just after a falling edge
   task automatic wr(input int a, input logic [DATA_W-1:0] d);
      reg_wr = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [DATA_W-1:0] v);
      reg_addr = ADDR_W'(a);
      #1;
      v = reg_rdata;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic chk_en(input string tag, input logic [3:0] exp);
      chk(tag, {cpu_clk_en, tick_clk_en, pic_clk_en, volt_low_req}, exp);
   endtask

   initial begin
      #(20 * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [DATA_W-1:0] v;
      @(negedge clk);
      do_reset();

      // R2: reset state
      chk_en("R2 enables after reset", 4'b1110);
      chk("R2 freq after reset (R1)", freq_lvl, 0);
      rd(1, v); chk("R2 settle reset value", v, 2);
      rd(2, v); chk("R2 status after reset R9", v, 8'b11_0_00);

      // table: mode entry and gating, R3 R4 R1
      for (int i = 0; i < 8; i++) begin
         do_reset();
         wr(0, {1'b0, VEC[i][8:6], VEC[i][12:9]});
         chk($sformatf("R1 freq vec%0d", i), freq_lvl, VEC[i][12:9]);
         chk_en($sformatf("R4 enables vec%0d", i), VEC[i][3:0]);
         rd(2, v); chk($sformatf("R3 mode vec%0d", i), v[1:0], VEC[i][5:4]);
         rd(0, v); chk($sformatf("R1 readback vec%0d", i), v, VEC[i][12:9]);
      end

      // doze, timer wake, settle 3: R5 R8 R10 R9
      do_reset();
      wr(1, 8'd3);
      wr(0, 8'h10);
      wr(0, 8'h47);   // R3: suspend request ignored in doze; R1 freq still updates
      rd(2, v); chk("R3 write ignored in doze", v[1:0], 1);
      chk("R1 freq updated in doze", freq_lvl, 7);
      chk_en("R4 doze enables kept", 4'b0110);
      tick_evt = 1'b1; @(negedge clk); tick_evt = 1'b0;   // edge k
      @(negedge clk);                                       // after k+1
      rd(2, v); chk("R10 no wake before sync delay", v[2], 0);
      @(negedge clk);                                       // after k+2 = W
      rd(2, v); chk("R5 doze wake on timer", v[2], 1);
      chk("R9 cause timer", v[4:3], 1);
      repeat (3) @(negedge clk);                            // after W+3
      chk_en("R8 clocks gated through settle", 4'b0110);
      @(negedge clk);                                       // after W+4
      chk_en("R8 clocks back after settle", 4'b1110);
      rd(2, v); chk("R9 status normal after wake", v[2:0], 0);

      // sleep: timer ignored, interrupt wakes, settle 2: R6 R8 R4
      do_reset();
      wr(0, 8'h20);
      tick_evt = 1'b1; @(negedge clk); tick_evt = 1'b0;
      repeat (5) @(negedge clk);
      rd(2, v); chk("R6 sleep ignores timer", v[2:0], 3'b0_10);
      chk_en("R6 sleep gating kept", 4'b0011);
      irq_pend = 1'b1;
      repeat (3) @(negedge clk);                            // after W
      chk_en("R8 volt drops first, clocks gated", 4'b0010);
      rd(2, v); chk("R9 cause interrupt", v[4:3], 2);
      irq_pend = 1'b0;
      repeat (2) @(negedge clk);                            // after W+2
      chk_en("R8 sleep settle hold", 4'b0010);
      @(negedge clk);
      chk_en("R8 sleep wake complete", 4'b1110);

      // suspend: only reset leaves, R7
      do_reset();
      wr(0, 8'h40);
      irq_pend = 1'b1;
      tick_evt = 1'b1; @(negedge clk); tick_evt = 1'b0;
      repeat (6) @(negedge clk);
      chk_en("R7 suspend ignores events", 4'b0001);
      rd(2, v); chk("R7 suspend mode held", v[2:0], 3'b0_11);
      irq_pend = 1'b0;
      do_reset();
      chk_en("R7 reset leaves suspend", 4'b1110);
      rd(2, v); chk("R7 cause reset", v[4:0], 5'b11_0_00);

      // doze, both sources, settle 0: R9 priority, R8 boundary
      do_reset();
      wr(1, 8'd0);
      wr(0, 8'h10);
      tick_evt = 1'b1; irq_pend = 1'b1;
      @(negedge clk); tick_evt = 1'b0;
      @(negedge clk); @(negedge clk);                       // after W
      irq_pend = 1'b0;
      rd(2, v); chk("R9 interrupt wins tie", v[4:3], 2);
      chk_en("R8 settle 0 first cycle gated", 4'b0110);
      @(negedge clk);
      chk_en("R8 settle 0 back next edge", 4'b1110);

      // doze, interrupt wake, settle 15, mode write during wake: R8 R3
      do_reset();
      wr(1, 8'd15);
      rd(1, v); chk("R8 settle readback", v, 15);
      wr(0, 8'h10);
      irq_pend = 1'b1;
      repeat (3) @(negedge clk);                            // after W
      irq_pend = 1'b0;
      wr(0, 8'h20);                                         // after W+1
      repeat (14) @(negedge clk);                           // after W+15
      chk_en("R8 settle 15 still gated", 4'b0110);
      rd(2, v); chk("R3 write ignored while waking", v[2:0], 3'b1_01);
      @(negedge clk);                                       // after W+16
      chk_en("R8 settle 15 released", 4'b1110);
      repeat (3) @(negedge clk);
      rd(2, v); chk("R3 no late entry after wake", v[1:0], 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule